// File: doc/BRIEF.md
# Four-Task Dependency Sequencer

This block orders the execution of a fixed graph of four tasks. Task A runs first. Tasks B and C both depend on A and may run in parallel. Task D depends on both B and C. The sequencer does not run any task itself. It waits for a request strobe from its user, pulses a start line for each task once that task's predecessors have finished, and collects the tasks' done pulses. When the final task reports done, it emits a one-cycle end pulse.

The two parallel branches are joined through sticky flags, so the done pulses of B and C may arrive in either order or in the same cycle. The request input and the end output form a start/finish handshake of the same shape as one task slot. A parent sequencer can therefore use a whole child sequencer as one of its tasks: the parent's start line drives the child's request, and the child's end pulse drives the parent's done line.

Done pulses for tasks that are not currently outstanding are discarded and raise a sticky error flag. Requests that arrive while a run is in progress are ignored.

Top module: `task_graph_seq`

## Requirements
- R1: After reset, `start_o` is 0, `end_o` is 0, `err_o` is 0 and `phase_o` is 0 (phase codes: 0 idle, 1 A running, 2 B/C running, 3 D running, 4 finishing).
- R2: A request sampled in phase 0 makes `start_o` equal 4'b0001 (bit 0 = A) in the next cycle, and the phase becomes 1.
- R3: `done_i[0]` sampled in phase 1 makes `start_o` equal 4'b0110 (bits 1 = B, 2 = C, together) in the next cycle, and the phase becomes 2.
- R4: `start_o[3]` (D) is pulsed only after both `done_i[1]` and `done_i[2]` have been seen, in either order, and it appears in the cycle after the later of the two.
- R5: `done_i[1]` and `done_i[2]` in the same cycle during phase 2 produce `start_o` = 4'b1000 in the next cycle.
- R6: `done_i[3]` sampled in phase 3 makes `end_o` high for exactly one cycle in phase 4. The phase returns to 0 in the following cycle, and a new request is accepted from then on.
- R7: Every start bit and `end_o` is a single-cycle pulse.
- R8: A request sampled outside phase 0 is ignored: it produces no start pulse and does not change the phase.
- R9: A done pulse for a task that is not outstanding (not started, or already reported) is ignored: it causes no output and no phase change. It sets `err_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Run request strobe |
| done_i | input | 4 | Per-task done pulses, bit 0 A .. bit 3 D |
| start_o | output | 4 | Per-task start pulses, bit 0 A .. bit 3 D |
| end_o | output | 1 | Graph completion pulse |
| phase_o | output | 3 | Current sequencing phase |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The two branch completions, B and C, can land in the same clock cycle. In that case the join has to record both and launch D in the same step. The bench provokes this by pulsing `done_i[1]` and `done_i[2]` together. It expects exactly one D start pulse, one cycle later, with nothing in between. It also runs both staggered orders and checks that no D pulse appears after only one branch has finished.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
    localparam int unsigned NTASK   = 4;
    localparam int unsigned NBRANCH = 2;
    localparam int unsigned PHASE_W = 3;

    localparam int unsigned TA = 0;
    localparam int unsigned TB = 1;
    localparam int unsigned TC = 2;
    localparam int unsigned TD = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE   = 3'd0,
        PH_RUN_A  = 3'd1,
        PH_RUN_BC = 3'd2,
        PH_RUN_D  = 3'd3,
        PH_FINISH = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [NTASK-1:0]   start;
    } seq_state_t;
endpackage

// File: rtl/tgs_join.sv
module tgs_join #(
    parameter int unsigned NBR = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           arm_i,
    input  logic [NBR-1:0] hit_i,
    output logic [NBR-1:0] seen_o,
    output logic           all_o
);
    logic [NBR-1:0] seen_d, seen_q;
    logic [NBR-1:0] merged;

    assign merged = seen_q | (hit_i & {NBR{arm_i}});
    assign all_o  = arm_i & (&merged);

    for (genvar g = 0; g < NBR; g++) begin : g_flag
        always_comb begin
            if (!arm_i || all_o) begin
                seen_d[g] = 1'b0;
            end else begin
                seen_d[g] = merged[g];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign seen_o = seen_q;
endmodule

// File: rtl/tgs_guard.sv
module tgs_guard #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] done_i,
    input  logic [N-1:0] pend_i,
    output logic [N-1:0] acc_o,
    output logic         err_o
);
    logic err_d, err_q;
    logic stray;

    assign acc_o = done_i & pend_i;
    assign stray = |(done_i & ~pend_i);

    always_comb begin
        err_d = err_q | stray;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_o = err_q;
endmodule

// File: rtl/task_graph_seq.sv
module task_graph_seq
    import tgs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic [NTASK-1:0] done_i,
    output logic [NTASK-1:0] start_o,
    output logic             end_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic             err_o
);
    seq_state_t st_d, st_q;

    logic [NTASK-1:0]   pend;
    logic [NTASK-1:0]   acc;
    logic [NBRANCH-1:0] seen;
    logic               join_all;
    logic               in_bc;

    assign in_bc = (st_q.phase == PH_RUN_BC);

    // Which tasks may legally report done this cycle
    always_comb begin
        pend = '0;
        unique case (st_q.phase)
            PH_RUN_A:  pend[TA] = 1'b1;
            PH_RUN_BC: begin
                pend[TB] = ~seen[0];
                pend[TC] = ~seen[1];
            end
            PH_RUN_D:  pend[TD] = 1'b1;
            default:   pend = '0;
        endcase
    end

    tgs_guard #(.N(NTASK)) u_guard (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .done_i (done_i),
        .pend_i (pend),
        .acc_o  (acc),
        .err_o  (err_o)
    );

    tgs_join #(.NBR(NBRANCH)) u_join (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (in_bc),
        .hit_i  (acc[TC:TB]),
        .seen_o (seen),
        .all_o  (join_all)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.phase     = PH_RUN_A;
                    st_d.start[TA] = 1'b1;
                end
            end
            PH_RUN_A: begin
                if (acc[TA]) begin
                    st_d.phase     = PH_RUN_BC;
                    st_d.start[TB] = 1'b1;
                    st_d.start[TC] = 1'b1;
                end
            end
            PH_RUN_BC: begin
                if (join_all) begin
                    st_d.phase     = PH_RUN_D;
                    st_d.start[TD] = 1'b1;
                end
            end
            PH_RUN_D: begin
                if (acc[TD]) begin
                    st_d.phase = PH_FINISH;
                end
            end
            PH_FINISH: st_d.phase = PH_IDLE;
            default:   st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.start <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign end_o   = (st_q.phase == PH_FINISH);
    assign phase_o = st_q.phase;
endmodule

// File: rtl/tgs_checker.sv
module tgs_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_i,
    input logic [3:0] done_i,
    input logic [3:0] start_o,
    input logic       end_o,
    input logic [2:0] phase_o,
    input logic       err_o
);
    a_r2_start_a_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 3'd0 && req_i) |=> (start_o == 4'b0001 && phase_o == 3'd1));

    a_r3_branches_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 3'd1 && done_i[0]) |=> (start_o == 4'b0110));

    a_r4_d_from_branch_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(start_o[3]) |-> ($past(phase_o) == 3'd2));

    a_r6_end_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_o |=> (!end_o && phase_o == 3'd0));

    a_r6_end_after_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 3'd3 && done_i[3]) |=> end_o);

    for (genvar g = 0; g < 4; g++) begin : g_pulse
        a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
            start_o[g] |=> !start_o[g]);
    end

    a_r8_req_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o != 3'd0 && req_i) |=> !start_o[0]);

    a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    a_r9_idle_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == 3'd0 && done_i != 4'b0000) |=> err_o);
endmodule

bind task_graph_seq tgs_checker chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .done_i  (done_i),
    .start_o (start_o),
    .end_o   (end_o),
    .phase_o (phase_o),
    .err_o   (err_o)
);

// File: tb/task_graph_seq_tb.sv
module task_graph_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [3:0] done = 4'b0000;
    logic [3:0] start;
    logic       fin;
    logic [2:0] phase;
    logic       err;

    int n_chk  = 0;
    int n_fail = 0;
    logic [4:0] exp_q[$];
    bit stop_mon = 1'b0;

    always #10 clk = ~clk;

    task_graph_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
        .start_o(start), .end_o(fin), .phase_o(phase), .err_o(err)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares every non-empty output event against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!stop_mon && rst_n && ({start, fin} != 5'b0)) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected output event", {3'b0, start, fin}, 8'h00);
                end else begin
                    check("R7 output event order", {3'b0, start, fin}, {3'b0, exp_q.pop_front()});
                end
            end
        end
    end

    // Driver: applies one cycle of inputs, posts the expected event
    task automatic step(input string tag, input logic r, input logic [3:0] d, input logic [4:0] ev);
        @(negedge clk);
        req  = r;
        done = d;
        if (ev != 5'b0) exp_q.push_back(ev);
        @(posedge clk);
        #1;
        req  = 1'b0;
        done = 4'b0000;
        #3;
        check({tag, " event consumed next cycle"}, 8'(exp_q.size()), 8'd0);
    endtask

    task automatic idle_cycle();
        step("idle", 1'b0, 4'b0000, 5'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check("R1 start", {4'b0, start}, 8'h00);
        check("R1 end", {7'b0, fin}, 8'h00);
        check("R1 phase", {5'b0, phase}, 8'h00);
        check("R1 err", {7'b0, err}, 8'h00);

        // Run 1: B before C
        step("R2 req", 1'b1, 4'b0000, 5'b00010);
        check("R2 phase", {5'b0, phase}, 8'd1);
        step("R8 req while busy", 1'b1, 4'b0000, 5'b0);
        check("R8 phase kept", {5'b0, phase}, 8'd1);
        step("R3 done A", 1'b0, 4'b0001, 5'b01100);
        check("R3 phase", {5'b0, phase}, 8'd2);
        step("R4 done B only", 1'b0, 4'b0010, 5'b0);
        check("R4 waits for C", {5'b0, phase}, 8'd2);
        idle_cycle();
        step("R4 done C", 1'b0, 4'b0100, 5'b10000);
        check("R4 phase D", {5'b0, phase}, 8'd3);
        step("R6 done D", 1'b0, 4'b1000, 5'b00001);
        check("R6 finishing phase", {5'b0, phase}, 8'd4);
        idle_cycle();
        check("R6 back to idle", {5'b0, phase}, 8'd0);
        check("R9 no error on clean run", {7'b0, err}, 8'd0);

        // Run 2: C before B, request right after idle return
        step("R6 new req", 1'b1, 4'b0000, 5'b00010);
        step("R3 done A", 1'b0, 4'b0001, 5'b01100);
        step("R4 done C first", 1'b0, 4'b0100, 5'b0);
        check("R4 waits for B", {5'b0, phase}, 8'd2);
        step("R4 done B", 1'b0, 4'b0010, 5'b10000);
        step("R6 done D", 1'b0, 4'b1000, 5'b00001);
        idle_cycle();

        // Run 3: B and C together
        step("R2 req", 1'b1, 4'b0000, 5'b00010);
        step("R3 done A", 1'b0, 4'b0001, 5'b01100);
        step("R5 done B and C", 1'b0, 4'b0110, 5'b10000);
        check("R5 phase D", {5'b0, phase}, 8'd3);
        step("R8 req in D", 1'b1, 4'b0000, 5'b0);
        check("R8 phase kept D", {5'b0, phase}, 8'd3);
        step("R6 done D", 1'b0, 4'b1000, 5'b00001);
        step("R8 req in finish", 1'b1, 4'b0000, 5'b0);
        check("R8 idle after finish", {5'b0, phase}, 8'd0);
        check("R9 still clean", {7'b0, err}, 8'd0);

        // R9: stray done pulses
        step("R9 done D while idle", 1'b0, 4'b1000, 5'b0);
        check("R9 err set", {7'b0, err}, 8'd1);
        check("R9 phase unchanged", {5'b0, phase}, 8'd0);
        step("R2 req", 1'b1, 4'b0000, 5'b00010);
        step("R9 done B before A", 1'b0, 4'b0010, 5'b0);
        check("R9 phase stays A", {5'b0, phase}, 8'd1);
        step("R3 done A", 1'b0, 4'b0001, 5'b01100);
        step("R9 done B", 1'b0, 4'b0010, 5'b0);
        step("R9 duplicate B", 1'b0, 4'b0010, 5'b0);
        check("R9 dup no advance", {5'b0, phase}, 8'd2);
        step("R9 done C", 1'b0, 4'b0100, 5'b10000);
        step("R6 done D", 1'b0, 4'b1000, 5'b00001);
        idle_cycle();
        check("R9 err sticky", {7'b0, err}, 8'd1);

        do_reset();
        #1;
        check("R1 err cleared by reset", {7'b0, err}, 8'd0);
        idle_cycle();
        check("R7 no leftover events", 8'(exp_q.size()), 8'd0);

        stop_mon = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule